// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog

This block is a memory-mapped watchdog with a 64-bit register port. A prescaler divides the system clock so that a 24-bit live count moves down once per 1024 clocks. Each time the count is found at zero on a tick, the watchdog escalates by one stage. The first expiry latches a pending interrupt. The second expiry emits a one-cycle intermediate event, which nothing downstream needs to act on. The third expiry raises a core reset request. That request stays high until the block's own reset.

Software arms the block by writing a control word. The word holds a 2-bit run mode, a 16-bit reload length and the live count. While the watchdog runs, software writes the poke register to restart the countdown and return the escalation to its first stage. A reload loads the length into the upper 16 bits of the count and clears the low 8 bits. Interrupt delivery is masked by an enable bit that has separate set and clear addresses. The pending bit is cleared by writing a one to it.

Top module: `wdt3_escalator`

## Requirements
- R1: After reset, the outputs `wd_irq`, `wd_stage2` and `wd_core_rst` are 0, and the control word, pending status and enable all read back as 0.
- R2: The control word is at offset 0x1F8. It holds the mode in bits [1:0], the length in bits [19:4] and the live count in bits [43:20], and all other bits read 0. The enable bit reads back as bit 63 at both 0x210 and 0x218. Reads of the poke offset 0x101F8 return 0.
- R3: When a nonzero mode is written while stopped, or after a poke, the prescaler starts from zero and ticks every 1024 clocks. A live count C expires on the (C+1)-th tick, which is exactly (C+1)*1024 clock edges after the write.
- R4: The first expiry sets the pending bit (bit 63 at 0x200) even when the enable bit is 0. Writing a 1 to bit 63 at 0x200 clears it, and writing 0 there leaves it set.
- R5: `wd_irq` is high exactly when the pending bit and the enable bit are both set and the mode is nonzero. Writing bit 63 at 0x218 sets the enable bit, and writing bit 63 at 0x210 clears it.
- R6: In mode 3, the second expiry drives `wd_stage2` high for exactly one cycle. Each non-final expiry reloads the count with the length in bits [23:8] and zeros in bits [7:0].
- R7: In mode 3, the third expiry raises `wd_core_rst`. It stays high through mode changes and pokes, and only the block reset `rst` clears it.
- R8: A write to 0x101F8 with bit 63 set reloads the count from the length, clears the prescaler and returns the stage to the first. A poke write with bit 63 clear has no effect.
- R9: While the mode is 0, the prescaler and the stage are held at zero, the count holds its value, and `wd_irq` and `wd_stage2` stay low.
- R10: In mode 1, every expiry repeats the first stage. In mode 2, every expiry after the first repeats the second stage. Neither mode ever raises `wd_core_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 17 | Byte offset of the register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid in the same cycle as `bus_rd` |
| wd_irq | output | 1 | Interrupt: pending and enabled |
| wd_stage2 | output | 1 | One-cycle pulse at the second expiry |
| wd_core_rst | output | 1 | Sticky core reset request after the third expiry |

## Verification
The bench places the first expiry on the exact clock edge for several starting counts. A prescaler that is off by one, or a count that expires on the C-th tick, moves the interrupt one edge or a whole tick away from the checked edge. The bench pokes between the first and second expiries. A poke that failed to reset the stage would then emit the intermediate pulse on the old schedule. Other directed cases cover the following, and an inverted clear or enable path shows up as a stuck or missing `wd_irq`:
- pending set while the interrupt is disabled;
- write-zero clears that must not clear;
- a stopped mode that must freeze the count;
- the shallower modes 1 and 2, which must never reach reset;
- a sticky reset that must survive a stop.

// File: rtl/wdt3_pkg.sv
package wdt3_pkg;
    localparam int DATA_W     = 64;
    localparam int ADDR_W     = 17;
    localparam int MODE_W     = 2;
    localparam int LEN_W      = 16;
    localparam int CNT_W      = 24;
    localparam int LEN_LSB    = 4;
    localparam int CNT_LSB    = 20;
    localparam int LOW_ZERO_W = CNT_W - LEN_W;

    localparam logic [MODE_W-1:0] MODE_STOP = 2'd0;

    typedef enum logic [1:0] {
        STG_INTR  = 2'd0,
        STG_EVENT = 2'd1,
        STG_RESET = 2'd2
    } stage_e;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [LEN_W-1:0]  len;
        logic [MODE_W-1:0] mode;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] ctrl_to_word(ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[MODE_W-1:0]         = c.mode;
        w[LEN_LSB +: LEN_W]   = c.len;
        w[CNT_LSB +: CNT_W]   = c.cnt;
        return w;
    endfunction

    function automatic logic [CNT_W-1:0] reload_of(logic [LEN_W-1:0] len);
        return {len, {LOW_ZERO_W{1'b0}}};
    endfunction
endpackage

// File: rtl/wdt3_prescaler.sv
module wdt3_prescaler #(
    parameter int DIV = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pcnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            pcnt_q <= '0;
        end else if (pcnt_q == LAST) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    assign tick = run && (pcnt_q == LAST);

    // R3: ticks are separated by at least one idle cycle
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/wdt3_escalate.sv
module wdt3_escalate
    import wdt3_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic              expire,
    input  logic              poke,
    input  logic              pend_clr,
    output logic              pending,
    output logic              stage2_pulse,
    output logic              core_rst,
    output logic              reload
);
    stage_e stage_q;
    logic   advance;

    assign advance = ({1'b0, stage_q} + 3'd1) < {1'b0, mode};
    assign reload  = expire && !poke && (stage_q != STG_RESET);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q      <= STG_INTR;
            pending      <= 1'b0;
            stage2_pulse <= 1'b0;
            core_rst     <= 1'b0;
        end else begin
            stage2_pulse <= 1'b0;
            if (pend_clr) begin
                pending <= 1'b0;
            end
            if (mode == MODE_STOP || poke) begin
                stage_q <= STG_INTR;
            end else if (expire) begin
                case (stage_q)
                    STG_INTR:  pending      <= 1'b1;
                    STG_EVENT: stage2_pulse <= 1'b1;
                    default:   core_rst     <= 1'b1;
                endcase
                if (advance) begin
                    case (stage_q)
                        STG_INTR:  stage_q <= STG_EVENT;
                        STG_EVENT: stage_q <= STG_RESET;
                        default:   stage_q <= STG_RESET;
                    endcase
                end
            end
        end
    end

    // R4: pending only rises from a first-stage expiry
    assert_pend_from_expiry_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(expire && stage_q == STG_INTR));
    // R6: the intermediate event is a single-cycle pulse
    assert_stage2_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        stage2_pulse |=> !stage2_pulse);
    // R7: the reset request is sticky
    assert_core_rst_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        core_rst |=> core_rst);
    // R7: the reset request only rises from the final stage
    assert_core_rst_final_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(core_rst) |-> $past(stage_q == STG_RESET));
    // R9: a stopped watchdog drops back to the first stage
    assert_stop_clears_stage_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STOP) |=> (stage_q == STG_INTR));
endmodule

// File: rtl/wdt3_regs.sv
module wdt3_regs
    import wdt3_pkg::*;
#(
    parameter int SLOT_IDX = 63
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick,
    input  logic              reload,
    input  logic              pending,
    output ctrl_t             ctrl,
    output logic              enable,
    output logic              poke,
    output logic              pend_clr
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8 * SLOT_IDX);
    localparam logic [ADDR_W-1:0] A_POKE = ADDR_W'(32'h1_0000 + 8 * SLOT_IDX);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(32'h200);
    localparam logic [ADDR_W-1:0] A_ECLR = ADDR_W'(32'h210);
    localparam logic [ADDR_W-1:0] A_ESET = ADDR_W'(32'h218);

    logic slot_bit, ctrl_wr;

    assign slot_bit = bus_wdata[SLOT_IDX];
    assign ctrl_wr  = bus_wr && bus_addr == A_CTRL;
    assign poke     = bus_wr && bus_addr == A_POKE && slot_bit;
    assign pend_clr = bus_wr && bus_addr == A_STAT && slot_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            enable <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl.mode <= bus_wdata[MODE_W-1:0];
                ctrl.len  <= bus_wdata[LEN_LSB +: LEN_W];
                ctrl.cnt  <= bus_wdata[CNT_LSB +: CNT_W];
            end else if (poke) begin
                ctrl.cnt <= reload_of(ctrl.len);
            end else if (tick) begin
                if (ctrl.cnt != '0) begin
                    ctrl.cnt <= ctrl.cnt - 1'b1;
                end else if (reload) begin
                    ctrl.cnt <= reload_of(ctrl.len);
                end
            end
            if (bus_wr && bus_addr == A_ESET && slot_bit) begin
                enable <= 1'b1;
            end else if (bus_wr && bus_addr == A_ECLR && slot_bit) begin
                enable <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_CTRL:         bus_rdata = ctrl_to_word(ctrl);
                A_STAT:         bus_rdata[SLOT_IDX] = pending;
                A_ECLR, A_ESET: bus_rdata[SLOT_IDX] = enable;
                default:        bus_rdata = '0;
            endcase
        end
    end

    // R8: a poke leaves the count at the scaled length
    assert_poke_reload_R8: assert property (@(posedge clk) disable iff (rst)
        poke |=> (ctrl.cnt == reload_of($past(ctrl.len))));
endmodule

// File: rtl/wdt3_escalator.sv
module wdt3_escalator
    import wdt3_pkg::*;
#(
    parameter int PRESC_DIV = 1024,
    parameter int SLOT_IDX  = 63
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_irq,
    output logic              wd_stage2,
    output logic              wd_core_rst
);
    ctrl_t ctrl;
    logic  enable, poke, pend_clr, tick, reload, pending, run, expire;

    assign run    = ctrl.mode != MODE_STOP;
    assign expire = tick && (ctrl.cnt == '0);
    assign wd_irq = pending && enable && run;

    wdt3_regs #(.SLOT_IDX(SLOT_IDX)) u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick(tick), .reload(reload), .pending(pending),
        .ctrl(ctrl), .enable(enable), .poke(poke), .pend_clr(pend_clr)
    );

    wdt3_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk(clk), .rst(rst), .run(run), .restart(poke), .tick(tick)
    );

    wdt3_escalate u_esc (
        .clk(clk), .rst(rst), .mode(ctrl.mode), .expire(expire),
        .poke(poke), .pend_clr(pend_clr), .pending(pending),
        .stage2_pulse(wd_stage2), .core_rst(wd_core_rst), .reload(reload)
    );

    // R9: a stopped watchdog keeps its count
    assert_stop_holds_count_R9: assert property (@(posedge clk) disable iff (rst)
        (!run && !bus_wr) |=> $stable(ctrl.cnt));
endmodule

// File: tb/wdt3_escalator_tb.sv
`timescale 1ns/1ps
module wdt3_escalator_tb;
    import wdt3_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL = 17'h001F8;
    localparam logic [ADDR_W-1:0] A_POKE = 17'h101F8;
    localparam logic [ADDR_W-1:0] A_STAT = 17'h00200;
    localparam logic [ADDR_W-1:0] A_ECLR = 17'h00210;
    localparam logic [ADDR_W-1:0] A_ESET = 17'h00218;
    localparam logic [63:0] B63 = 64'h8000_0000_0000_0000;

    // stimulus count and expected edge of first expiry (R3: (C+1)*1024)
    localparam int NVEC = 4;
    localparam int VEC_CNT  [NVEC] = '{0, 1, 2, 4};
    localparam int VEC_EDGE [NVEC] = '{1024, 2048, 3072, 5120};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic wd_irq, wd_stage2, wd_core_rst;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    wdt3_escalator u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wd_irq(wd_irq), .wd_stage2(wd_stage2), .wd_core_rst(wd_core_rst)
    );

    function automatic logic [63:0] mk(int mode, int len, int cnt);
        return (64'(cnt) << 20) | (64'(len) << 4) | 64'(mode);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [63:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] rd;
        int pulses;

        // R1: reset state
        do_reset();
        chk("R1 irq", 64'(wd_irq), 64'd0);
        chk("R1 stage2", 64'(wd_stage2), 64'd0);
        chk("R1 core_rst", 64'(wd_core_rst), 64'd0);
        bus_read(A_CTRL, rd); chk("R1 ctrl", rd, 64'd0);
        bus_read(A_STAT, rd); chk("R1 status", rd, 64'd0);
        bus_read(A_ESET, rd); chk("R1 enable", rd, 64'd0);

        // R2: field layout, junk bits dropped
        bus_write(A_CTRL, mk(0, 16'hABCD, 24'h123456) | 64'hC000_0000_0000_000C);
        bus_read(A_CTRL, rd); chk("R2 ctrl fields", rd, mk(0, 16'hABCD, 24'h123456));
        bus_read(A_POKE, rd); chk("R2 poke reads zero", rd, 64'd0);
        bus_write(A_ESET, B63);
        bus_read(A_ECLR, rd); chk("R2 enable at clr", rd, B63);
        bus_read(A_ESET, rd); chk("R2 enable at set", rd, B63);

        // R8: poke reloads from length; poke without bit 63 ignored
        bus_write(A_POKE, B63);
        bus_read(A_CTRL, rd); chk("R8 poke reload", rd, mk(0, 16'hABCD, 24'hABCD00));
        bus_write(A_CTRL, mk(0, 16'hABCD, 5));
        bus_write(A_POKE, 64'h4000_0000_0000_0000);
        bus_read(A_CTRL, rd); chk("R8 poke no bit63", rd, mk(0, 16'hABCD, 5));

        // R9: stopped mode freezes everything
        bus_write(A_CTRL, mk(0, 0, 2));
        wait_edges(4096);
        chk("R9 irq low", 64'(wd_irq), 64'd0);
        bus_read(A_CTRL, rd); chk("R9 count held", rd, mk(0, 0, 2));
        bus_read(A_STAT, rd); chk("R9 no pending", rd, 64'd0);

        // R3/R4/R6/R7: vector table walk, mode 3
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            bus_write(A_ESET, B63);
            bus_write(A_CTRL, mk(3, 0, VEC_CNT[v]));
            wait_edges(VEC_EDGE[v] - 1);
            chk("R3 before first expiry", 64'(wd_irq), 64'd0);
            wait_edges(1);
            chk("R3 R4 first expiry irq", 64'(wd_irq), 64'd1);
            wait_edges(1023);
            chk("R6 before second expiry", 64'(wd_stage2), 64'd0);
            wait_edges(1);
            chk("R6 second expiry pulse", 64'(wd_stage2), 64'd1);
            wait_edges(1);
            chk("R6 pulse one cycle", 64'(wd_stage2), 64'd0);
            wait_edges(1022);
            chk("R7 before third expiry", 64'(wd_core_rst), 64'd0);
            wait_edges(1);
            chk("R7 third expiry reset", 64'(wd_core_rst), 64'd1);
        end

        // R7: sticky through stop and poke, cleared by rst
        bus_write(A_CTRL, mk(0, 0, 0));
        bus_write(A_POKE, B63);
        wait_edges(10);
        chk("R7 sticky", 64'(wd_core_rst), 64'd1);
        do_reset();
        chk("R7 cleared by rst", 64'(wd_core_rst), 64'd0);

        // R4: pending while disabled, write-one-to-clear
        bus_write(A_CTRL, mk(3, 0, 0));
        wait_edges(1024);
        chk("R4 irq masked", 64'(wd_irq), 64'd0);
        bus_read(A_STAT, rd); chk("R4 pending set", rd, B63);
        bus_write(A_STAT, 64'd0);
        bus_read(A_STAT, rd); chk("R4 write zero keeps", rd, B63);
        bus_write(A_STAT, B63);
        bus_read(A_STAT, rd); chk("R4 cleared", rd, 64'd0);

        // R5: enable gating and stop gating
        do_reset();
        bus_write(A_ESET, B63);
        bus_write(A_CTRL, mk(3, 0, 0));
        wait_edges(1024);
        chk("R5 irq on", 64'(wd_irq), 64'd1);
        bus_write(A_ECLR, B63);
        chk("R5 irq off after clr", 64'(wd_irq), 64'd0);
        bus_read(A_STAT, rd); chk("R5 pending kept", rd, B63);
        bus_write(A_ESET, B63);
        chk("R5 irq back", 64'(wd_irq), 64'd1);
        bus_write(A_CTRL, mk(0, 0, 0));
        chk("R5 R9 irq off when stopped", 64'(wd_irq), 64'd0);

        // R8: poke returns the stage to the first
        do_reset();
        bus_write(A_CTRL, mk(3, 0, 0));
        wait_edges(1524);
        bus_write(A_POKE, B63);
        wait_edges(522);
        chk("R8 old schedule no pulse", 64'(wd_stage2), 64'd0);
        wait_edges(502);
        chk("R8 first stage again", 64'(wd_stage2), 64'd0);
        wait_edges(1024);
        chk("R8 R6 pulse after restart", 64'(wd_stage2), 64'd1);

        // R10: mode 1 and mode 2 depth limits
        do_reset();
        bus_write(A_CTRL, mk(1, 0, 0));
        pulses = 0;
        for (int i = 0; i < 4200; i++) begin
            @(negedge clk);
            if (wd_stage2) pulses++;
        end
        chk("R10 mode1 no pulse", 64'(pulses), 64'd0);
        chk("R10 mode1 no reset", 64'(wd_core_rst), 64'd0);
        bus_read(A_STAT, rd); chk("R10 mode1 pending", rd, B63);
        do_reset();
        bus_write(A_CTRL, mk(2, 0, 0));
        pulses = 0;
        for (int i = 0; i < 4200; i++) begin
            @(negedge clk);
            if (wd_stage2) pulses++;
        end
        chk("R10 mode2 repeats pulse", 64'(pulses), 64'd3);
        chk("R10 mode2 no reset", 64'(wd_core_rst), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule